// File: doc/BRIEF.md
# UART Receive Buffer with FIFO Status

This block is the receive-side buffer of a UART peripheral. A deserializer hands it one character at a time, along with parity and framing error indications and a separate line-break indication. The block stores the characters in a first-in first-out queue, or in a single holding register when queueing is switched off. Software sees four word registers: a FIFO control register, a FIFO status register, an error status register and a receive-data register. From these, software can pop characters, read the fill level, see and clear errors, and flush the queue. The block also drives a data-ready level and two sticky source flags, one for receive and one for error, which a separate interrupt controller masks and clears.

Queue occupancy is tracked by a small state machine. `FILL_EMPTY` moves to `FILL_PARTIAL` on an accepted push. When the depth is one, that push moves it straight to `FILL_FULL`. `FILL_PARTIAL` moves to `FILL_FULL` when a lone push lands on the last free slot. It moves back to `FILL_EMPTY` when a lone pop removes the last character. `FILL_FULL` returns to `FILL_PARTIAL` on a lone pop, or to `FILL_EMPTY` when the depth is one. A flush takes any state to `FILL_EMPTY`. A push and a pop in the same cycle leave the state and the count where they were.

The register interface is word addressed: 0 is control, 1 is status, 2 is error, 3 is data. Read data is combinational while `reg_rd` is high. Side effects of a read, such as a pop or clear-on-read, take effect at the clock edge that ends the strobe. Every state change lands at the rising edge where the stimulus is sampled.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the control, status and error registers read 0, and `data_ready`, `src_rx`, `src_err`, `fifo_en` and `tx_flush` are 0.
- R2: Control bit 0 enables FIFO mode. Bits 6:4 hold the receive trigger level and bits 10:8 the transmit trigger level; both appear on `rx_trig`/`tx_trig`. Bits 1 and 2 always read back as 0. Writing bit 2 drives `tx_flush` high for exactly the one cycle after the write.
- R3: Writing control bit 1 empties the receive queue, so the count reads 0 and `data_ready` drops after that edge.
- R4: In FIFO mode, reading the data register returns the oldest stored character in bits 7:0 and removes it. `data_ready` stays high only while characters remain.
- R5: Status bits 7:0 give the stored count and bit 8 is the full flag. When the queue is full, bits 7:0 read 0 and only bit 8 is set.
- R6: A data read in FIFO mode while the queue is empty returns 0 and sets `src_err`.
- R7: A character that arrives while the queue is full, with no pop in the same cycle, is discarded. This sets `src_err` and error status bit 0 (overrun).
- R8: Every arriving character or break sets `src_rx` and makes `data_ready` high once it is stored.
- R9: With FIFO mode off, a character goes into a single holding register and sets `data_ready`. Reading the data register returns it and clears `data_ready`. A new character that arrives while `data_ready` is still set replaces the old one and sets error bit 0.
- R10: A break stores a 0x00 character (queue or holding register) and sets error status bit 3.
- R11: Error bit 1 (parity) and bit 2 (framing) latch from `rx_perr`/`rx_ferr` on a character arrival. Reading the error register returns its value and clears it. An event in the same cycle as that read is kept.
- R12: Writes to the status, error and data registers change nothing.
- R13: A push and a pop in the same cycle leave the count unchanged, including when the queue is full.
- R14: `src_clr[0]` clears `src_rx` and `src_clr[1]` clears `src_err`. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Deserializer delivers a character this cycle |
| rx_byte | input | 8 | Delivered character |
| rx_perr | input | 1 | Parity error on the delivered character |
| rx_ferr | input | 1 | Framing error on the delivered character |
| rx_break | input | 1 | Line break detected this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word address: 0 control, 1 status, 2 error, 3 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while `reg_rd` is high |
| src_clr | input | 2 | Clear strobes for `src_rx` (bit 0) and `src_err` (bit 1) |
| data_ready | output | 1 | Received data is available |
| src_rx | output | 1 | Sticky receive source flag |
| src_err | output | 1 | Sticky error source flag |
| fifo_en | output | 1 | FIFO mode enabled |
| rx_trig | output | 3 | Receive trigger-level field |
| tx_trig | output | 3 | Transmit trigger-level field |
| tx_flush | output | 1 | One-cycle transmit queue flush request |

## Verification
The properties assume that `rx_valid` and `rx_break` never rise in the same cycle, and that `reg_wr` and `reg_rd` are never high together. The bench drives every input from single-purpose tasks that assert exactly one of these at a time, except for the deliberate same-cycle pop-and-push and read-with-event cases, which respect both rules. The bench also treats the read value as meaningful only while the strobe is high. It holds each strobe for exactly one clock, so each read produces exactly one side effect.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
    localparam int REG_AW = 2;

    typedef enum logic [1:0] {
        RA_CTRL   = 2'd0,
        RA_STATUS = 2'd1,
        RA_ERROR  = 2'd2,
        RA_DATA   = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        FILL_EMPTY   = 2'd0,
        FILL_PARTIAL = 2'd1,
        FILL_FULL    = 2'd2
    } fill_state_e;

    // control register bit positions
    localparam int CTL_EN      = 0;
    localparam int CTL_RXFLUSH = 1;
    localparam int CTL_TXFLUSH = 2;
    localparam int CTL_RXTRG   = 4;
    localparam int CTL_TXTRG   = 8;
    localparam int TRG_W       = 3;

    // error status bit positions
    localparam int ERR_OVR = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_FRM = 2;
    localparam int ERR_BRK = 3;
    localparam int ERR_W   = 4;

    // status register full flag
    localparam int STAT_FULL = 8;
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam bit POW2  = (DEPTH == (1 << PTR_W));

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W-1:0] wr_inc, rd_inc;

    generate
        if (POW2) begin : g_wrap_free
            assign wr_inc = wr_ptr + 1'b1;
            assign rd_inc = rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_inc;
            if (pop)  rd_ptr <= rd_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= wdata;
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/rxb_fill_fsm.sv
module rxb_fill_fsm
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    output fill_state_e      state,
    output logic [CNT_W-1:0] count,
    output logic             is_empty,
    output logic             is_full
);
    localparam bit ONE_DEEP = (DEPTH == 1);

    fill_state_e      nxt_state;
    logic [CNT_W-1:0] nxt_count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FILL_EMPTY;
            count <= '0;
        end else begin
            state <= nxt_state;
            count <= nxt_count;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_count = count;
        if (flush) begin
            nxt_state = FILL_EMPTY;
            nxt_count = '0;
        end else begin
            if (push && !pop) nxt_count = count + 1'b1;
            if (pop && !push) nxt_count = count - 1'b1;
            unique case (state)
                FILL_EMPTY: begin
                    if (push && !pop) nxt_state = ONE_DEEP ? FILL_FULL : FILL_PARTIAL;
                end
                FILL_PARTIAL: begin
                    if (push && !pop && count == CNT_W'(DEPTH - 1))
                        nxt_state = FILL_FULL;
                    else if (pop && !push && count == CNT_W'(1))
                        nxt_state = FILL_EMPTY;
                end
                FILL_FULL: begin
                    if (pop && !push) nxt_state = ONE_DEEP ? FILL_EMPTY : FILL_PARTIAL;
                end
                default: nxt_state = FILL_EMPTY;
            endcase
        end
    end

    always_comb begin
        is_empty = (state == FILL_EMPTY);
        is_full  = (state == FILL_FULL);
    end
endmodule

// File: rtl/rxb_csr.sv
module rxb_csr
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_break,
    input  logic [1:0]        src_clr,
    input  logic [7:0]        q_head,
    input  logic [CNT_W-1:0]  q_count,
    input  logic              q_empty,
    input  logic              q_full,
    output logic              q_push,
    output logic              q_pop,
    output logic              q_flush,
    output logic [7:0]        q_wdata,
    output logic              data_ready,
    output logic              src_rx,
    output logic              src_err,
    output logic              fifo_en,
    output logic [TRG_W-1:0]  rx_trig,
    output logic [TRG_W-1:0]  tx_trig,
    output logic              tx_flush
);
    logic             ctl_wr, data_rd, err_rd;
    logic             arrive, dropped, empty_rd;
    logic             hold_load, hold_ovr, hold_rdy;
    logic [7:0]       hold_q;
    logic [ERR_W-1:0] err_q, err_set;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:11], reg_wdata[7], reg_wdata[3]};

    always_comb begin
        ctl_wr    = reg_wr && (reg_addr == RA_CTRL);
        data_rd   = reg_rd && (reg_addr == RA_DATA);
        err_rd    = reg_rd && (reg_addr == RA_ERROR);
        arrive    = rx_valid || rx_break;
        q_wdata   = rx_break ? 8'h00 : rx_byte;
        q_flush   = ctl_wr && reg_wdata[CTL_RXFLUSH];
        q_pop     = data_rd && fifo_en && !q_empty;
        q_push    = arrive && fifo_en && (!q_full || q_pop);
        dropped   = arrive && fifo_en && q_full && !q_pop;
        empty_rd  = data_rd && fifo_en && q_empty;
        hold_load = arrive && !fifo_en;
        hold_ovr  = hold_load && hold_rdy && !data_rd;
        err_set            = '0;
        err_set[ERR_OVR]   = dropped || hold_ovr;
        err_set[ERR_PAR]   = rx_valid && !rx_break && rx_perr;
        err_set[ERR_FRM]   = rx_valid && !rx_break && rx_ferr;
        err_set[ERR_BRK]   = rx_break;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en  <= 1'b0;
            rx_trig  <= '0;
            tx_trig  <= '0;
            tx_flush <= 1'b0;
        end else begin
            tx_flush <= ctl_wr && reg_wdata[CTL_TXFLUSH];
            if (ctl_wr) begin
                fifo_en <= reg_wdata[CTL_EN];
                rx_trig <= reg_wdata[CTL_RXTRG +: TRG_W];
                tx_trig <= reg_wdata[CTL_TXTRG +: TRG_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q    <= '0;
            src_rx   <= 1'b0;
            src_err  <= 1'b0;
            hold_q   <= '0;
            hold_rdy <= 1'b0;
        end else begin
            err_q   <= (err_rd ? '0 : err_q) | err_set;
            src_rx  <= (src_rx && !src_clr[0]) || arrive;
            src_err <= (src_err && !src_clr[1]) || dropped || empty_rd;
            if (hold_load) begin
                hold_q   <= q_wdata;
                hold_rdy <= 1'b1;
            end else if (data_rd && !fifo_en) begin
                hold_rdy <= 1'b0;
            end
        end
    end

    assign data_ready = fifo_en ? !q_empty : hold_rdy;

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                RA_CTRL: begin
                    reg_rdata[CTL_EN]              = fifo_en;
                    reg_rdata[CTL_RXTRG +: TRG_W]  = rx_trig;
                    reg_rdata[CTL_TXTRG +: TRG_W]  = tx_trig;
                end
                RA_STATUS: begin
                    if (q_full) reg_rdata[STAT_FULL] = 1'b1;
                    else        reg_rdata[7:0]       = 8'(q_count);
                end
                RA_ERROR: reg_rdata[ERR_W-1:0] = err_q;
                RA_DATA: begin
                    if (!fifo_en)     reg_rdata[7:0] = hold_q;
                    else if (!q_empty) reg_rdata[7:0] = q_head;
                end
                default: reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_perr,
    input  logic        rx_ferr,
    input  logic        rx_break,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [1:0]  src_clr,
    output logic        data_ready,
    output logic        src_rx,
    output logic        src_err,
    output logic        fifo_en,
    output logic [2:0]  rx_trig,
    output logic [2:0]  tx_trig,
    output logic        tx_flush
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    fill_state_e      fill_state;
    logic [CNT_W-1:0] fill_count;
    logic             q_empty, q_full, push_ok, pop_ok, flush_rx;
    logic [7:0]       q_head, q_wdata;

    rxb_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_rx),
        .push  (push_ok),
        .pop   (pop_ok),
        .wdata (q_wdata),
        .head  (q_head)
    );

    rxb_fill_fsm #(.DEPTH(DEPTH)) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_rx),
        .push     (push_ok),
        .pop      (pop_ok),
        .state    (fill_state),
        .count    (fill_count),
        .is_empty (q_empty),
        .is_full  (q_full)
    );

    rxb_csr #(.DEPTH(DEPTH)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .rx_perr    (rx_perr),
        .rx_ferr    (rx_ferr),
        .rx_break   (rx_break),
        .src_clr    (src_clr),
        .q_head     (q_head),
        .q_count    (fill_count),
        .q_empty    (q_empty),
        .q_full     (q_full),
        .q_push     (push_ok),
        .q_pop      (pop_ok),
        .q_flush    (flush_rx),
        .q_wdata    (q_wdata),
        .data_ready (data_ready),
        .src_rx     (src_rx),
        .src_err    (src_err),
        .fifo_en    (fifo_en),
        .rx_trig    (rx_trig),
        .tx_trig    (tx_trig),
        .tx_flush   (tx_flush)
    );
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             push_ok,
    input logic             pop_ok,
    input logic             flush_rx,
    input logic [CNT_W-1:0] fill_count,
    input logic [1:0]       fill_state,
    input logic             data_ready,
    input logic             src_err,
    input logic             reg_rd,
    input logic [1:0]       reg_addr
);
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    assert_full_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_state == FILL_FULL) |-> (fill_count == CNT_W'(DEPTH)));

    assert_push_pop_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok && !flush_rx) |=> (fill_count == $past(fill_count)));

    assert_empty_read_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RA_DATA && fifo_en && fill_state == FILL_EMPTY) |=> src_err);

    assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_rx |=> (fill_count == '0));

    assert_ready_tracks_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |-> (data_ready == (fill_count != '0)));
endmodule

bind uart_rx_buffer rxb_checker #(.DEPTH(DEPTH)) u_rxb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok),
    .flush_rx   (flush_rx),
    .fill_count (fill_count),
    .fill_state (fill_state),
    .data_ready (data_ready),
    .src_err    (src_err),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr)
);

// File: tb/test_uart_rx_buffer.sv
`timescale 1ns/100ps
module test_uart_rx_buffer;
    localparam int DEPTH = 4;
    localparam int WD_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_break = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  src_clr = '0;
    logic        data_ready, src_rx, src_err, fifo_en, tx_flush;
    logic [2:0]  rx_trig, tx_trig;

    int checks = 0;
    int failures = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    uart_rx_buffer #(.DEPTH(DEPTH)) i_uart_rx_buffer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_break(rx_break),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_clr(src_clr),
        .data_ready(data_ready), .src_rx(src_rx), .src_err(src_err),
        .fifo_en(fifo_en), .rx_trig(rx_trig), .tx_trig(tx_trig), .tx_flush(tx_flush)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: every FIFO-mode data read is compared with the queue head
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mon_on && reg_rd && reg_addr == 2'd3) begin
                if (exp_q.size() > 0) chk("R4 pop order", reg_rdata, {24'h0, exp_q.pop_front()});
                else                  chk("R6 empty read value", reg_rdata, 32'h0);
            end
        end
    end

    task automatic send(input logic [7:0] b, input logic pe = 1'b0, input logic fe = 1'b0);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_perr = pe; rx_ferr = fe;
        if (mon_on && exp_q.size() < DEPTH) exp_q.push_back(b);
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
    endtask

    task automatic send_break();
        @(negedge clk);
        rx_break = 1'b1;
        if (mon_on && exp_q.size() < DEPTH) exp_q.push_back(8'h00);
        @(negedge clk);
        rx_break = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic clr_src();
        @(negedge clk);
        src_clr = 2'b11;
        @(negedge clk);
        src_clr = 2'b00;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 data_ready", data_ready, 0);
        chk("R1 src_rx", src_rx, 0);
        chk("R1 src_err", src_err, 0);
        chk("R1 fifo_en", fifo_en, 0);
        chk("R1 tx_flush", tx_flush, 0);
        rd_reg(2'd0, rv); chk("R1 control", rv, 0);
        rd_reg(2'd1, rv); chk("R1 status", rv, 0);
        rd_reg(2'd2, rv); chk("R1 error", rv, 0);

        // R9 holding register mode, R8 arrival flags
        send(8'hA5);
        #1 chk("R8 data_ready", data_ready, 1);
        chk("R8 src_rx", src_rx, 1);
        rd_reg(2'd3, rv); chk("R9 hold read", rv, 32'hA5);
        #1 chk("R9 ready cleared", data_ready, 0);
        send(8'h11);
        send(8'h22);
        rd_reg(2'd2, rv); chk("R9 overwrite overrun", rv, 32'h1);
        rd_reg(2'd2, rv); chk("R11 clear on read", rv, 32'h0);

        // R12 writes to read-only registers
        wr_reg(2'd3, 32'hFF);
        wr_reg(2'd2, 32'hF);
        wr_reg(2'd1, 32'h1FF);
        rd_reg(2'd2, rv); chk("R12 error untouched", rv, 32'h0);
        rd_reg(2'd1, rv); chk("R12 status untouched", rv, 32'h0);
        #1 chk("R12 ready untouched", data_ready, 1);
        rd_reg(2'd3, rv); chk("R12 hold untouched", rv, 32'h22);

        // R14 source clears
        clr_src();
        #1 chk("R14 src_rx cleared", src_rx, 0);
        chk("R14 src_err cleared", src_err, 0);

        // R2 control register
        wr_reg(2'd0, 32'h357);
        #1 chk("R2 tx_flush pulse", tx_flush, 1);
        @(negedge clk); #1 chk("R2 tx_flush single", tx_flush, 0);
        chk("R2 fifo_en", fifo_en, 1);
        chk("R2 rx_trig", rx_trig, 3'd5);
        chk("R2 tx_trig", tx_trig, 3'd3);
        rd_reg(2'd0, rv); chk("R2 readback", rv, 32'h351);

        // FIFO mode
        mon_on = 1'b1;
        send(8'h10); send(8'h20); send(8'h30);
        rd_reg(2'd1, rv); chk("R5 count", rv, 32'h3);
        rd_reg(2'd3, rv);
        #1 chk("R4 ready after pop", data_ready, 1);
        send(8'h40); send(8'h50);
        rd_reg(2'd1, rv); chk("R5 full reads zero count", rv, 32'h100);
        send(8'h60);
        #1 chk("R7 src_err on drop", src_err, 1);
        rd_reg(2'd2, rv); chk("R7 overrun bit", rv, 32'h1);

        // R13 push and pop together while full
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h70; reg_rd = 1'b1; reg_addr = 2'd3;
        #3 exp_q.push_back(8'h70);
        @(negedge clk);
        rx_valid = 1'b0; reg_rd = 1'b0;
        rd_reg(2'd1, rv); chk("R13 count held", rv, 32'h100);

        rd_reg(2'd3, rv); rd_reg(2'd3, rv); rd_reg(2'd3, rv);
        #1 chk("R4 ready with one left", data_ready, 1);
        rd_reg(2'd3, rv);
        #1 chk("R4 ready after last pop", data_ready, 0);

        // R6 empty read
        clr_src();
        rd_reg(2'd3, rv); chk("R6 returns zero", rv, 32'h0);
        #1 chk("R6 src_err", src_err, 1);

        // R10 break
        send_break();
        rd_reg(2'd2, rv); chk("R10 break bit", rv, 32'h8);
        rd_reg(2'd1, rv); chk("R10 null stored", rv, 32'h1);
        rd_reg(2'd3, rv); chk("R10 null value", rv, 32'h0);

        // R11 parity/framing and same-cycle retention
        send(8'h5A, 1'b1, 1'b1);
        rd_reg(2'd2, rv); chk("R11 parity+frame", rv, 32'h6);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 2'd2; rx_valid = 1'b1; rx_byte = 8'h6B; rx_perr = 1'b1;
        exp_q.push_back(8'h6B);
        #1 chk("R11 read before event", reg_rdata, 32'h0);
        @(negedge clk);
        reg_rd = 1'b0; rx_valid = 1'b0; rx_perr = 1'b0;
        rd_reg(2'd2, rv); chk("R11 event kept", rv, 32'h2);
        rd_reg(2'd3, rv); rd_reg(2'd3, rv);

        // R3 receive flush
        send(8'h81); send(8'h82);
        wr_reg(2'd0, 32'h353);
        exp_q.delete();
        #1 chk("R3 ready dropped", data_ready, 0);
        chk("R3 no tx flush", tx_flush, 0);
        rd_reg(2'd1, rv); chk("R3 count zero", rv, 32'h0);
        rd_reg(2'd0, rv); chk("R3 flush bit self-clears", rv, 32'h351);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule